// File: doc/BRIEF.md
# Motor Speed Edge Phase Comparator with Masked Lock Detect

This block is the digital front end of a motor speed phase-locked loop. Two asynchronous inputs come in: a reference clock and the motor's FG pulse, which is derived from one Hall phase and rises when that phase goes from low to high. The block compares the reference clock's falling edges with the FG rising edges. In regulation the two have the same frequency. It produces tri-state phase-error pulses on `up` and `down` for an external loop filter, and the width of each pulse is the phase error.

Every completed comparison measures the width of its error pulse in system clock cycles and checks it against a programmable limit. Lock is reported on the active-low `lockN` output only after enough slow ticks have passed without a comparison going over the limit. This masks short unlock dips during pull-in. A single over-limit comparison drops lock at once. While locked, `driveHalf` asks the power stage for half drive gain. The `decel` output flags that the FG edge led the reference edge on the last comparison, meaning the motor is running fast. Pulling `run` low returns the comparator and the lock mask to idle.

Top module: `phaseLockDetect`

## Requirements
- R1: After reset, `up`, `down` and `decel` are 0, `lockN` is 1 and `driveHalf` is 0.
- R2: Both edge inputs pass through a two-stage synchronizer. A falling edge on `refIn` applied before a clock edge sets `up` on the third rising clock edge counted from that edge. A rising edge on `fgIn` sets `down` the same way. A rising `refIn` edge and a falling `fgIn` edge have no effect.
- R3: While one of `up` and `down` is pending, the detected edge of the other input clears both on the edge where it is registered, and that ends a comparison. Edges of both inputs registered on the same clock edge end a zero-width comparison with neither output set.
- R4: `up` and `down` are never high together.
- R5: The width of a comparison is the number of cycles its pulse was high. A width above `errLimit` sets `lockN` to 1 on the edge that ends the comparison. A width equal to `errLimit` or below it does not.
- R6: `lockN` goes low only once `MASK_TICKS` tick pulses (default 7) have been counted. A tick is counted only if a within-limit comparison has ended since the last clear.
- R7: When an over-limit comparison and a tick pulse fall on the same clock edge, the clear wins. The full `MASK_TICKS` fresh ticks are then needed again.
- R8: At the end of each comparison, `decel` becomes 1 if the FG edge came first (`down` was pending). Otherwise it becomes 0.
- R9: While `run` is low, `up`, `down`, the mask count, the width count and `decel` are cleared and `lockN` is 1.
- R10: `driveHalf` is 1 exactly when `lockN` is 0.
- R11: The width counter saturates at 2^CNT_W-1 (4095 by default). It does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start (1) / stop (0) |
| refIn | input | 1 | Asynchronous reference clock |
| fgIn | input | 1 | Asynchronous FG signal from Hall phase 1 |
| tick | input | 1 | One-cycle slow mask tick, synchronous to clk |
| errLimit | input | CNT_W | Largest error width that counts as in lock |
| up | output | 1 | Phase error pulse: reference edge leads |
| down | output | 1 | Phase error pulse: FG edge leads |
| decel | output | 1 | Motor fast, deceleration requested |
| lockN | output | 1 | Active-low lock indication |
| driveHalf | output | 1 | Half drive gain select |

## Verification
The collision that matters here is an over-limit comparison ending on the same clock edge on which a mask tick is sampled. The bench provokes it by driving the FG rise of an over-wide pulse and then raising `tick` exactly two negative edges later. The tick is then sampled on the edge where the synchronized FG edge closes the pulse. The result is judged by `lockN` staying high, and by lock coming back only after a full new run of seven qualified ticks. If the tick had been counted, lock would return one tick early. A behavioural model running alongside cross-checks every output on every cycle.

// File: rtl/pld_pkg.sv
package pld_pkg;
  // Strobes from the comparator control to the measurement datapath
  typedef struct packed {
    logic cmpDone;  // a comparison ends on this edge
    logic fgLead;   // the FG edge was the pending one
    logic cntEn;    // an error pulse is high this cycle
    logic cntClr;   // restart the width measurement
  } pdStrobe_t;
endpackage

// File: rtl/pldEdgeSync.sv
module pldEdgeSync #(
  parameter int STAGES = 2,
  parameter bit RISE   = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic edgeOut
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], sigIn};
  end

  generate
    if (RISE) begin : g_rise
      assign edgeOut = pipe[STAGES-1] & ~pipe[STAGES];
    end else begin : g_fall
      assign edgeOut = ~pipe[STAGES-1] & pipe[STAGES];
    end
  endgenerate
endmodule

// File: rtl/pldCtrl.sv
module pldCtrl
  import pld_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      run,
  input  logic      refIn,
  input  logic      fgIn,
  output logic      upQ,
  output logic      dnQ,
  output pdStrobe_t strobe
);
  logic refEv, fgEv, nextUp, nextDn, done;

  pldEdgeSync #(.STAGES(SYNC_STAGES), .RISE(1'b0)) i_refSync (
    .clk(clk), .rstN(rstN), .sigIn(refIn), .edgeOut(refEv));
  pldEdgeSync #(.STAGES(SYNC_STAGES), .RISE(1'b1)) i_fgSync (
    .clk(clk), .rstN(rstN), .sigIn(fgIn), .edgeOut(fgEv));

  always_comb begin
    nextUp         = upQ | refEv;
    nextDn         = dnQ | fgEv;
    done           = run & nextUp & nextDn;
    strobe.cmpDone = done;
    strobe.fgLead  = dnQ;
    strobe.cntEn   = run & (upQ | dnQ);
    strobe.cntClr  = ~run | done;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else if (!run || done) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= nextUp;
      dnQ <= nextDn;
    end
  end
endmodule

// File: rtl/pldPath.sv
module pldPath
  import pld_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int MASK_TICKS = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] errLimit,
  input  pdStrobe_t        strobe,
  output logic             decel,
  output logic             lockN,
  output logic             driveHalf
);
  localparam int MASK_W = $clog2(MASK_TICKS + 1);
  localparam logic [MASK_W-1:0] MASK_FULL = MASK_W'(MASK_TICKS);
  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  widthCnt, measured;
  logic [MASK_W-1:0] maskCnt;
  logic goodSeen, overLimit, badCmp, goodCmp, qualified, maskFull;

  always_comb begin
    measured  = (strobe.cntEn && widthCnt != CNT_MAX) ? widthCnt + 1'b1 : widthCnt;
    overLimit = measured > errLimit;
    badCmp    = strobe.cmpDone & overLimit;
    goodCmp   = strobe.cmpDone & ~overLimit;
    qualified = goodSeen | goodCmp;
    maskFull  = maskCnt == MASK_FULL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              widthCnt <= '0;
    else if (strobe.cntClr) widthCnt <= '0;
    else                    widthCnt <= measured;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskCnt  <= '0;
      goodSeen <= 1'b0;
      decel    <= 1'b0;
    end else if (!run) begin
      maskCnt  <= '0;
      goodSeen <= 1'b0;
      decel    <= 1'b0;
    end else begin
      if (badCmp) begin
        maskCnt  <= '0;
        goodSeen <= 1'b0;
      end else begin
        if (goodCmp) goodSeen <= 1'b1;
        if (tick && qualified && !maskFull) maskCnt <= maskCnt + 1'b1;
      end
      if (strobe.cmpDone) decel <= strobe.fgLead;
    end
  end

  assign lockN     = ~maskFull;
  assign driveHalf = maskFull;
endmodule

// File: rtl/phaseLockDetect.sv
module phaseLockDetect
  import pld_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 12,
  parameter int MASK_TICKS  = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             refIn,
  input  logic             fgIn,
  input  logic             tick,
  input  logic [CNT_W-1:0] errLimit,
  output logic             up,
  output logic             down,
  output logic             decel,
  output logic             lockN,
  output logic             driveHalf
);
  pdStrobe_t strobe;

  pldCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .refIn(refIn), .fgIn(fgIn),
    .upQ(up), .dnQ(down), .strobe(strobe));

  pldPath #(.CNT_W(CNT_W), .MASK_TICKS(MASK_TICKS)) i_path (
    .clk(clk), .rstN(rstN), .run(run), .tick(tick), .errLimit(errLimit),
    .strobe(strobe), .decel(decel), .lockN(lockN), .driveHalf(driveHalf));
endmodule

// File: rtl/pldCheck.sv
module pldCheck (
  input logic clk,
  input logic rstN,
  input logic run,
  input logic tick,
  input logic up,
  input logic down,
  input logic decel,
  input logic lockN
);
  a_r4_up_dn_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(up && down));

  // R3: a pending pulse is ended, never joined, by the partner edge
  a_r3_up_no_partner: assert property (@(posedge clk) disable iff (!rstN)
    up |=> !down);
  a_r3_dn_no_partner: assert property (@(posedge clk) disable iff (!rstN)
    down |=> !up);

  a_r9_run_clears: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (!up && !down && lockN && !decel));

  a_r6_lock_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockN) |-> $past(tick));
endmodule

bind phaseLockDetect pldCheck i_pldCheck (
  .clk(clk), .rstN(rstN), .run(run), .tick(tick), .up(up), .down(down),
  .decel(decel), .lockN(lockN));

// File: tb/test_phaseLockDetect.sv
module test_phaseLockDetect;
  localparam int CNT_W = 12;
  localparam int MASK_TICKS = 7;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic run = 1'b0;
  logic refIn = 1'b1;
  logic fgIn = 1'b0;
  logic tick = 1'b0;
  logic [CNT_W-1:0] errLimit = 12'd4;
  logic up, down, decel, lockN, driveHalf;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  phaseLockDetect #(.SYNC_STAGES(2), .CNT_W(CNT_W), .MASK_TICKS(MASK_TICKS)) i_phaseLockDetect (
    .clk(clk), .rstN(rstN), .run(run), .refIn(refIn), .fgIn(fgIn), .tick(tick),
    .errLimit(errLimit), .up(up), .down(down), .decel(decel), .lockN(lockN),
    .driveHalf(driveHalf));

  // Behavioural reference model
  bit refHist[$];
  bit fgHist[$];
  bit mUp, mDn, mGood, mDecel;
  int mCnt, mMask;

  always @(posedge clk) begin
    if (!rstN) begin
      refHist = '{0, 0, 0, 0};
      fgHist  = '{0, 0, 0, 0};
      mUp = 0; mDn = 0; mGood = 0; mDecel = 0; mCnt = 0; mMask = 0;
    end else begin
      bit rf, fr, nu, nd, pend, bad;
      int w;
      refHist.push_front(refIn); void'(refHist.pop_back());
      fgHist.push_front(fgIn);   void'(fgHist.pop_back());
      rf = refHist[3] && !refHist[2];
      fr = !fgHist[3] && fgHist[2];
      if (!run) begin
        mUp = 0; mDn = 0; mGood = 0; mDecel = 0; mCnt = 0; mMask = 0;
      end else begin
        nu = mUp || rf;
        nd = mDn || fr;
        pend = mUp || mDn;
        if (nu && nd) begin
          w = pend ? ((mCnt + 1 > CMAX) ? CMAX : mCnt + 1) : mCnt;
          bad = w > int'(errLimit);
          if (bad) begin
            mMask = 0; mGood = 0;
          end else begin
            mGood = 1;
            if (tick && mMask < MASK_TICKS) mMask++;
          end
          mDecel = mDn;
          mUp = 0; mDn = 0; mCnt = 0;
        end else begin
          if (pend) mCnt = (mCnt + 1 > CMAX) ? CMAX : mCnt + 1;
          mUp = nu; mDn = nd;
          if (tick && mGood && mMask < MASK_TICKS) mMask++;
        end
      end
    end
  end

  task automatic checkVal(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit mLock;
      mLock = (mMask == MASK_TICKS);
      checkVal("R2", "up model", up, mUp);
      checkVal("R2", "down model", down, mDn);
      checkVal("R6", "lockN model", lockN, !mLock);
      checkVal("R10", "driveHalf model", driveHalf, mLock);
      checkVal("R8", "decel model", decel, mDecel);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pairRefFirst(int g);
    refIn = 1'b0; cyc(g); fgIn = 1'b1; cyc(4);
    refIn = 1'b1; fgIn = 1'b0; cyc(4);
  endtask

  task automatic pairFgFirst(int g);
    fgIn = 1'b1; cyc(g); refIn = 1'b0; cyc(4);
    refIn = 1'b1; fgIn = 1'b0; cyc(4);
  endtask

  task automatic goodTick();
    pairRefFirst(2);
    tick = 1'b1; cyc(1); tick = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      finish();
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    checkVal("R1", "up", up, 0);
    checkVal("R1", "down", down, 0);
    checkVal("R1", "decel", decel, 0);
    checkVal("R1", "lockN", lockN, 1);
    checkVal("R1", "driveHalf", driveHalf, 0);
    run = 1'b1; cyc(5);

    // R2 latency, then R3 pairing clears both
    refIn = 1'b0; cyc(2);
    checkVal("R2", "up before 3rd edge", up, 0);
    cyc(1);
    checkVal("R2", "up at 3rd edge", up, 1);
    fgIn = 1'b1; cyc(3);
    checkVal("R3", "up after pair", up, 0);
    checkVal("R3", "down after pair", down, 0);
    refIn = 1'b1; fgIn = 1'b0; cyc(4);
    checkVal("R2", "up after ref rise", up, 0);
    checkVal("R2", "down after fg fall", down, 0);

    // R3 simultaneous edges
    refIn = 1'b0; fgIn = 1'b1; cyc(3);
    checkVal("R3", "up simultaneous", up, 0);
    checkVal("R3", "down simultaneous", down, 0);
    refIn = 1'b1; fgIn = 1'b0; cyc(4);

    // R6 mask count
    for (int i = 0; i < MASK_TICKS; i++) begin
      goodTick();
      if (i == MASK_TICKS - 2) checkVal("R6", "lockN after 6 ticks", lockN, 1);
    end
    checkVal("R6", "lockN after 7 ticks", lockN, 0);
    checkVal("R10", "driveHalf locked", driveHalf, 1);
    checkVal("R8", "decel ref first", decel, 0);

    // R8 decel; R5 boundary
    pairFgFirst(2);
    checkVal("R8", "decel fg first", decel, 1);
    checkVal("R5", "lockN under limit", lockN, 0);
    pairRefFirst(4);
    checkVal("R5", "lockN at limit", lockN, 0);
    checkVal("R8", "decel cleared", decel, 0);
    pairRefFirst(5);
    checkVal("R5", "lockN over limit", lockN, 1);
    checkVal("R10", "driveHalf unlocked", driveHalf, 0);

    // R7 same-cycle bad comparison and tick
    for (int i = 0; i < 3; i++) goodTick();
    refIn = 1'b0; cyc(6); fgIn = 1'b1; cyc(2);
    tick = 1'b1; cyc(1); tick = 1'b0;
    checkVal("R7", "lockN at collision", lockN, 1);
    refIn = 1'b1; fgIn = 1'b0; cyc(4);
    for (int i = 0; i < MASK_TICKS - 1; i++) goodTick();
    checkVal("R7", "lockN one tick short", lockN, 1);
    goodTick();
    checkVal("R7", "lockN relocked", lockN, 0);

    // R9 run low
    refIn = 1'b0; cyc(4);
    checkVal("R9", "up pending", up, 1);
    run = 1'b0; cyc(1);
    checkVal("R9", "up cleared", up, 0);
    checkVal("R9", "lockN cleared", lockN, 1);
    run = 1'b1; refIn = 1'b1; cyc(4);
    fgIn = 1'b1; cyc(4);
    checkVal("R9", "fresh down after stop", down, 1);
    refIn = 1'b0; cyc(4);
    refIn = 1'b1; fgIn = 1'b0; cyc(4);

    // R11 saturation
    for (int i = 0; i < MASK_TICKS; i++) goodTick();
    checkVal("R11", "locked before long pulse", lockN, 0);
    errLimit = 12'd4094;
    pairRefFirst(4100);
    checkVal("R11", "saturated width over limit", lockN, 1);
    errLimit = 12'd4;
    cyc(4);
    finish();
  end
endmodule